// File: doc/BRIEF.md
# Four-Channel LED Dimming and Blinking PWM Engine

This block turns a set of brightness and control values into drive levels for four LED channels. Each channel runs its own fast 8-bit brightness PWM. A slower group PWM can be combined with it. The group PWM works in one of two ways: as a dimmer at a fixed rate, or as a blinker whose period is set in 256 steps. A 2-bit state field per channel selects one of four behaviours: dark, fully lit, brightness PWM, or brightness PWM gated by the group signal.

An active-low output enable overrides all channels. While it is high, a 2-bit select forces every pin low, high, or high-impedance. A drive-type bit chooses between totem-pole and open-drain behaviour. In open-drain mode a high level is expressed by deasserting the channel's output enable. A sleep bit freezes the timebase and holds the channel levels.

All timing comes from clock-enable ticks that are divided down from one system clock. Each duty or period value is captured when its own counter wraps, so a change made in the middle of a period never produces a runt pulse.

Top module: `led_pwm_engine`

## Requirements
- R1: With channel state 10, a channel is lit for exactly d of every 256 individual steps, where d is its brightness byte. A byte of 00h never lights the channel, and FFh lights it for 255 of 256 steps.
- R2: The channel state field is encoded as 00 = dark, 01 = lit constantly, 10 = individual PWM, and 11 = individual PWM ANDed with the group signal.
- R3: With the blink-mode bit at 0, the group signal is high for g of every 256 group steps, with one step every DIM_DIV clocks, where g is the group duty byte. The period byte has no effect in this mode.
- R4: With the blink-mode bit at 1, one group period lasts (p+1)*256 blink ticks and the group signal is high for (p+1)*g of them, where p is the period byte.
- R5: Reset puts the captured brightness values at 00h, the group duty at FFh, the period at 00h and the mode at dimming. A new brightness value takes effect only at the next wrap of the individual counter, and new group values only at the next wrap of the group counter.
- R6: While oe_n is low, led_level is the inverse of the lit state when invert is 0, and equals the lit state when invert is 1. With drv_totem at 0, a high level deasserts led_oe for that channel. With drv_totem at 1, led_oe stays asserted.
- R7: While oe_n is high, a disable select of 00 drives every pin low (level 0, led_oe 1). A select of 01 gives level 1, with led_oe equal to drv_totem.
- R8: While oe_n is high, a disable select of 10 or 11 deasserts led_oe on every channel.
- R9: While sleep is 1, the counters stop and the channel levels hold, whatever the brightness, state or group inputs do. When sleep returns to 0, the outputs respond again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_duty | input | NUM_CH*8 | Brightness byte per channel, channel 0 in the low byte |
| grp_duty | input | 8 | Group duty byte |
| grp_period | input | 8 | Blink period byte |
| blink_mode | input | 1 | 0 = group dimming, 1 = group blinking |
| chan_mode | input | NUM_CH*2 | 2-bit state per channel, channel 0 in bits 1:0 |
| invert | input | 1 | Output polarity select |
| drv_totem | input | 1 | 1 = totem-pole, 0 = open-drain |
| sleep | input | 1 | Freeze timebase and levels |
| oe_n | input | 1 | Active-low output enable |
| dis_sel | input | 2 | Pin state while oe_n is high |
| led_level | output | NUM_CH | Logic level per channel pin |
| led_oe | output | NUM_CH | Drive enable per channel pin |

## Verification
The bench builds the block with IND_DIV = 1, DIM_DIV = 2 and BLINK_DIV = 1. With these values one individual period is 256 clocks, one dimming period is 512 clocks, and one blink period is (p+1)*256 clocks. This makes it affordable to sweep all 256 brightness values across the four channels and to measure several group duty and period values over whole periods. Counting lit cycles over one full period gives exact brightness figures. For the group modes, the count is bounded by the group on-time minus the individual-off cycles that fall inside the window. Running from a fresh reset brings the captured reset values and the wrap-time update within reach.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'b00,
    CH_FULL = 2'b01,
    CH_IND  = 2'b10,
    CH_GRP  = 2'b11
  } ch_mode_e;

  typedef enum logic [1:0] {
    DIS_LOW  = 2'b00,
    DIS_HIGH = 2'b01,
    DIS_HIZ  = 2'b10,
    DIS_RSVD = 2'b11
  } dis_sel_e;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/led_ind_pwm.sv
module led_ind_pwm #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DUTY_W  = 8,
  parameter int unsigned IND_DIV = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [NUM_CH*DUTY_W-1:0] duty_flat,
  output logic [NUM_CH-1:0]        pwm_on
);
  logic              tick;
  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic              wrap;

  led_tick_gen #(.DIV(IND_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  assign wrap = tick && (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DUTY_W-1:0] duty_q, duty_d;

    always_comb begin
      duty_d = duty_q;
      if (wrap) duty_d = duty_flat[i*DUTY_W +: DUTY_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q <= '0;
      else        duty_q <= duty_d;
    end

    assign pwm_on[i] = (cnt_q < duty_q);
  end
endmodule

// File: rtl/led_group_timebase.sv
module led_group_timebase #(
  parameter int unsigned DUTY_W    = 8,
  parameter int unsigned DIM_DIV   = 512,
  parameter int unsigned BLINK_DIV = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DUTY_W-1:0] grp_duty,
  input  logic [DUTY_W-1:0] grp_period,
  input  logic              blink_mode,
  output logic              grp_on
);
  logic              dim_tick, blink_tick;
  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic [DUTY_W-1:0] step_q, step_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DUTY_W-1:0] period_q, period_d;
  logic              mode_q, mode_d;
  logic              blink_step, grp_step, wrap;

  led_tick_gen #(.DIV(DIM_DIV)) u_dim_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(dim_tick)
  );

  led_tick_gen #(.DIV(BLINK_DIV)) u_blink_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(blink_tick)
  );

  assign blink_step = blink_tick && (step_q == period_q);
  assign grp_step   = mode_q ? blink_step : dim_tick;
  assign wrap       = grp_step && (cnt_q == '1);

  always_comb begin
    cnt_d    = cnt_q;
    step_d   = step_q;
    duty_d   = duty_q;
    period_d = period_q;
    mode_d   = mode_q;
    if (blink_tick) begin
      if (step_q == period_q) step_d = '0;
      else                    step_d = step_q + 1'b1;
    end
    if (grp_step) cnt_d = cnt_q + 1'b1;
    if (wrap) begin
      duty_d   = grp_duty;
      period_d = grp_period;
      mode_d   = blink_mode;
      step_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      step_q   <= '0;
      duty_q   <= '1;
      period_q <= '0;
      mode_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      step_q   <= step_d;
      duty_q   <= duty_d;
      period_q <= period_d;
      mode_q   <= mode_d;
    end
  end

  assign grp_on = (cnt_q < duty_q);
endmodule

// File: rtl/led_out_stage.sv
module led_out_stage
  import led_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [2*NUM_CH-1:0] mode_flat,
  input  logic [NUM_CH-1:0]   pwm_on,
  input  logic                grp_on,
  input  logic                invert,
  input  logic                drv_totem,
  input  logic                oe_n,
  input  logic [1:0]          dis_sel,
  output logic [NUM_CH-1:0]   led_level,
  output logic [NUM_CH-1:0]   led_oe
);
  dis_sel_e sel;
  assign sel = dis_sel_e'(dis_sel);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ch_mode_e m;
    logic     lit;
    logic     level_d, level_q;

    assign m = ch_mode_e'(mode_flat[2*i +: 2]);

    always_comb begin
      unique case (m)
        CH_OFF:  lit = 1'b0;
        CH_FULL: lit = 1'b1;
        CH_IND:  lit = pwm_on[i];
        CH_GRP:  lit = pwm_on[i] & grp_on;
        default: lit = 1'b0;
      endcase
      level_d = level_q;
      if (run) level_d = invert ? lit : ~lit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= level_d;
    end

    always_comb begin
      if (!oe_n) begin
        led_level[i] = level_q;
        led_oe[i]    = drv_totem | ~level_q;
      end else begin
        unique case (sel)
          DIS_LOW: begin
            led_level[i] = 1'b0;
            led_oe[i]    = 1'b1;
          end
          DIS_HIGH: begin
            led_level[i] = 1'b1;
            led_oe[i]    = drv_totem;
          end
          default: begin
            led_level[i] = 1'b0;
            led_oe[i]    = 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/led_pwm_engine.sv
module led_pwm_engine #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned IND_DIV   = 1,
  parameter int unsigned DIM_DIV   = 512,
  parameter int unsigned BLINK_DIV = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH*8-1:0]   ind_duty,
  input  logic [7:0]            grp_duty,
  input  logic [7:0]            grp_period,
  input  logic                  blink_mode,
  input  logic [NUM_CH*2-1:0]   chan_mode,
  input  logic                  invert,
  input  logic                  drv_totem,
  input  logic                  sleep,
  input  logic                  oe_n,
  input  logic [1:0]            dis_sel,
  output logic [NUM_CH-1:0]     led_level,
  output logic [NUM_CH-1:0]     led_oe
);
  localparam int unsigned DUTY_W = 8;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              run;
  logic [NUM_CH-1:0] pwm_on;
  logic              grp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign run = ~sleep;

  led_ind_pwm #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .IND_DIV(IND_DIV)) u_ind (
    .clk(clk), .rst_n(rst_int_n), .run(run),
    .duty_flat(ind_duty), .pwm_on(pwm_on)
  );

  led_group_timebase #(.DUTY_W(DUTY_W), .DIM_DIV(DIM_DIV), .BLINK_DIV(BLINK_DIV)) u_grp (
    .clk(clk), .rst_n(rst_int_n), .run(run),
    .grp_duty(grp_duty), .grp_period(grp_period), .blink_mode(blink_mode),
    .grp_on(grp_on)
  );

  led_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst_n(rst_int_n), .run(run),
    .mode_flat(chan_mode), .pwm_on(pwm_on), .grp_on(grp_on),
    .invert(invert), .drv_totem(drv_totem),
    .oe_n(oe_n), .dis_sel(dis_sel),
    .led_level(led_level), .led_oe(led_oe)
  );
endmodule

// File: rtl/led_pwm_engine_chk.sv
module led_pwm_engine_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH*2-1:0] chan_mode,
  input logic                invert,
  input logic                drv_totem,
  input logic                sleep,
  input logic                oe_n,
  input logic [1:0]          dis_sel,
  input logic [NUM_CH-1:0]   led_level,
  input logic [NUM_CH-1:0]   led_oe
);
  assert_dis_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && dis_sel == 2'b00) |-> (led_level == '0 && led_oe == '1));

  assert_dis_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && dis_sel == 2'b01) |-> (led_level == '1 && led_oe == {NUM_CH{drv_totem}}));

  assert_dis_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && dis_sel[1]) |-> (led_oe == '0));

  assert_open_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !drv_totem) |-> ((led_oe & led_level) == '0));

  assert_ch0_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(chan_mode[1:0]) == 2'b00 && !$past(sleep) &&
     !$past(invert) && !oe_n) |-> led_level[0]);

  assert_ch0_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(chan_mode[1:0]) == 2'b01 && !$past(sleep) &&
     !$past(invert) && !oe_n) |-> !led_level[0]);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep) && !oe_n && !$past(oe_n)) |-> $stable(led_level));
endmodule

bind led_pwm_engine led_pwm_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .chan_mode(chan_mode), .invert(invert),
  .drv_totem(drv_totem), .sleep(sleep), .oe_n(oe_n), .dis_sel(dis_sel),
  .led_level(led_level), .led_oe(led_oe)
);

// File: tb/tb_led_pwm_engine.sv
module tb_led_pwm_engine;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH*8-1:0] ind_duty;
  logic [7:0]     grp_duty, grp_period;
  logic           blink_mode;
  logic [NCH*2-1:0] chan_mode;
  logic           invert, drv_totem, sleep, oe_n;
  logic [1:0]     dis_sel;
  logic [NCH-1:0] led_level, led_oe;

  int checks = 0;
  int errors = 0;
  int lit_cnt [NCH];
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_pwm_engine #(.NUM_CH(NCH), .IND_DIV(1), .DIM_DIV(2), .BLINK_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .ind_duty(ind_duty), .grp_duty(grp_duty),
    .grp_period(grp_period), .blink_mode(blink_mode), .chan_mode(chan_mode),
    .invert(invert), .drv_totem(drv_totem), .sleep(sleep), .oe_n(oe_n),
    .dis_sel(dis_sel), .led_level(led_level), .led_oe(led_oe)
  );

  task automatic chk_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic measure(int n);
    for (int k = 0; k < NCH; k++) lit_cnt[k] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++) if (!led_level[k]) lit_cnt[k]++;
    end
  endtask

  task automatic set_modes(logic [1:0] m);
    chan_mode = {NCH{m}};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] held;
    bit same;
    rst_n      = 1'b0;
    ind_duty   = {NCH{8'd255}};
    grp_duty   = 8'd0;
    grp_period = 8'd0;
    blink_mode = 1'b0;
    set_modes(2'b11);
    invert     = 1'b0;
    drv_totem  = 1'b1;
    sleep      = 1'b0;
    oe_n       = 1'b0;
    dis_sel    = 2'b00;

    // R5: reset state, outputs dark (level high, driven)
    repeat (2) @(negedge clk);
    chk_eq("R5 reset level", led_level, 4'hF);
    chk_eq("R5 reset oe", led_oe, 4'hF);

    // R5: captured brightness is 00h until first individual wrap
    do_reset();
    measure(200);
    chk_eq("R5 ind reset value ch0", lit_cnt[0], 0);
    // R5: captured group duty FFh until first group wrap (~514 clocks)
    repeat (80) @(negedge clk);
    measure(220);
    chk_rng("R5 grp reset value ch0", lit_cnt[0], 218, 220);
    // R3: after group wrap, group duty 0 takes effect
    repeat (600) @(negedge clk);
    measure(512);
    chk_eq("R3 group duty zero ch1", lit_cnt[1], 0);

    // R1: sweep all 256 brightness values over the four channels
    set_modes(2'b10);
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < NCH; k++) ind_duty[k*8 +: 8] = 8'(4*i + k);
      repeat (258) @(negedge clk);
      measure(256);
      for (int k = 0; k < NCH; k++) chk_eq($sformatf("R1 duty %0d", 4*i + k), lit_cnt[k], 4*i + k);
    end

    // R2: full on and off encodings
    set_modes(2'b01);
    repeat (2) @(negedge clk);
    measure(256);
    chk_eq("R2 full on", lit_cnt[2], 256);
    set_modes(2'b00);
    repeat (2) @(negedge clk);
    measure(256);
    chk_eq("R2 off", lit_cnt[3], 0);

    // R2: mixed encodings; ch3 gated by group FF in dim mode
    ind_duty = {8'd100, 8'd100, 8'd77, 8'd77};
    grp_duty = 8'd255;
    chan_mode = {2'b11, 2'b10, 2'b01, 2'b00};
    repeat (1100) @(negedge clk);
    measure(512);
    chk_eq("R2 mixed off", lit_cnt[0], 0);
    chk_eq("R2 mixed full", lit_cnt[1], 512);
    chk_eq("R2 mixed ind", lit_cnt[2], 200);
    chk_rng("R2 mixed grp", lit_cnt[3], 198, 200);

    // R3: dimming, period byte ignored
    set_modes(2'b11);
    ind_duty   = {NCH{8'd255}};
    grp_period = 8'd9;
    foreach (lit_cnt[j]) lit_cnt[j] = 0;
    for (int t = 0; t < 3; t++) begin
      int g;
      g = (t == 0) ? 64 : (t == 1) ? 200 : 255;
      grp_duty = 8'(g);
      repeat (1100) @(negedge clk);
      measure(512);
      chk_rng($sformatf("R3 dim g=%0d", g), lit_cnt[t], 2*g - 2, 2*g);
    end

    // R4: blinking with several periods
    blink_mode = 1'b1;
    for (int t = 0; t < 3; t++) begin
      int p, g;
      p = (t == 0) ? 0 : (t == 1) ? 2 : 5;
      g = (t == 0) ? 40 : (t == 1) ? 128 : 250;
      grp_period = 8'(p);
      grp_duty   = 8'(g);
      repeat (3200) @(negedge clk);
      measure((p + 1) * 256);
      chk_rng($sformatf("R4 blink p=%0d g=%0d", p, g), lit_cnt[t], (p + 1) * g - (p + 1), (p + 1) * g);
    end
    blink_mode = 1'b0;

    // R6: polarity and drive type
    set_modes(2'b01);
    repeat (2) @(negedge clk);
    chk_eq("R6 lit level invert0", led_level, 4'h0);
    invert = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R6 lit level invert1", led_level, 4'hF);
    chk_eq("R6 totem oe", led_oe, 4'hF);
    invert    = 1'b0;
    drv_totem = 1'b0;
    chan_mode = {2'b00, 2'b01, 2'b00, 2'b01};
    repeat (2) @(negedge clk);
    chk_eq("R6 open drain level", led_level, 4'b1010);
    chk_eq("R6 open drain oe", led_oe, 4'b0101);

    // R7/R8: disabled states for both drive types
    oe_n = 1'b1;
    for (int tt = 0; tt < 2; tt++) begin
      drv_totem = tt[0];
      for (int s = 0; s < 4; s++) begin
        dis_sel = 2'(s);
        #1;
        if (s == 0) begin
          chk_eq("R7 sel00 level", led_level, 4'h0);
          chk_eq("R7 sel00 oe", led_oe, 4'hF);
        end else if (s == 1) begin
          chk_eq("R7 sel01 level", led_level, 4'hF);
          chk_eq("R7 sel01 oe", led_oe, tt ? 4'hF : 4'h0);
        end else begin
          chk_eq($sformatf("R8 sel%0d oe", s), led_oe, 4'h0);
        end
      end
    end
    oe_n      = 1'b0;
    drv_totem = 1'b1;
    dis_sel   = 2'b00;

    // R9: sleep holds levels
    set_modes(2'b10);
    ind_duty = {8'd10, 8'd90, 8'd170, 8'd250};
    repeat (600) @(negedge clk);
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    held = led_level;
    chan_mode = {2'b01, 2'b00, 2'b01, 2'b00};
    ind_duty  = {NCH{8'd3}};
    same = 1'b1;
    repeat (600) begin
      @(negedge clk);
      if (led_level != held) same = 1'b0;
    end
    chk_eq("R9 sleep holds levels", same, 1);
    sleep = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R9 wake responds", led_level, 4'b0101);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule